// File: doc/BRIEF.md
# Serial Master Shift Engine with Hardware Parity

This block is the shift engine of a synchronous serial master. A single strobe launches one frame. The frame carries a right-aligned payload word of programmable length, sent most significant bit first. When hardware parity is active, one generated parity bit follows the payload. The payload word never sets aside a position for parity, so a 16-bit payload becomes a 17-bit frame on the wire.

The receive side takes in as many bits as it sends. When parity is active, it separates the trailing parity bit from the payload and keeps that bit in a status flag of its own. It also flags a mismatch between that bit and the parity recomputed over the received payload.

The serial clock idles low and is derived from the system clock by a fixed divider. The slave select is active low and frames the transfer with one half-period of margin at each end. A one-cycle completion pulse marks the point where every result becomes valid. Byte mode switches hardware parity off no matter what the parity enable says.

Top module: `spi_par_master`

## Requirements
- R1: A frame carries `data_len`+1 payload bits, taken from the low end of `tx_data` and sent on `mosi` most significant bit first; bits of `tx_data` above the payload length are not sent.
- R2: With `par_en`=1 and `byte_mode`=0, exactly one parity bit is sent in the slot after the payload LSB, so the frame is `data_len`+2 bits long.
- R3: With `par_odd`=0, the number of ones across the payload and the parity bit is even; with `par_odd`=1 it is odd.
- R4: With `par_en`=0 or `byte_mode`=1, the frame is `data_len`+1 bits long, and after completion `tx_par`, `rx_par` and `par_err` read 0.
- R5: After completion, `tx_par` holds the parity bit that was sent in that frame.
- R6: `miso` is sampled on each rising `sclk` edge. The first payload-length bits received appear right-aligned in `rx_data`, first received bit most significant, with upper bits 0. When parity is active, the last received bit is kept out of `rx_data` and appears in `rx_par`.
- R7: When parity is active, `par_err` is 1 after completion exactly when `rx_par` differs from the parity of `rx_data` for the selected type.
- R8: `sclk` is low whenever `cs_n` is high and stays low for HALF_DIV clocks after `cs_n` falls. Each half-period lasts HALF_DIV clocks, and `mosi` changes only while `sclk` is low.
- R9: `cs_n` rises HALF_DIV clocks after the last falling `sclk` edge, so a frame of N bits holds `cs_n` low for (2N+1)·HALF_DIV clocks. `done` is high for exactly one clock, the first clock with `cs_n` high again.
- R10: A `start` pulse that arrives while a frame is in progress is ignored: it neither changes the frame in flight nor launches a second frame.
- R11: After reset, `cs_n`=1, `sclk`=0, `mosi`=0, `done`=0, and `rx_data`, `tx_par`, `rx_par` and `par_err` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Launch a frame (accepted only when idle) |
| tx_data | input | DATA_W | Right-aligned payload to send |
| data_len | input | $clog2(DATA_W) | Payload length minus one |
| par_en | input | 1 | Append a hardware parity bit |
| par_odd | input | 1 | 0 = even parity, 1 = odd parity |
| byte_mode | input | 1 | Disables hardware parity when 1 |
| miso | input | 1 | Serial data from the slave |
| sclk | output | 1 | Serial clock, idle low |
| mosi | output | 1 | Serial data to the slave |
| cs_n | output | 1 | Slave select, active low |
| rx_data | output | DATA_W | Received payload, right-aligned |
| tx_par | output | 1 | Parity bit sent in the last frame |
| rx_par | output | 1 | Parity bit received in the last frame |
| par_err | output | 1 | Received parity mismatch |
| done | output | 1 | One-clock completion pulse |

## Verification
The hardest case to reach from the ports is a received parity bit that disagrees with the received payload. A correct slave never produces one, so the bench slave model builds each reply frame from its own payload and parity. For a chosen subset of lengths and parity types it inverts the parity bit before shifting it out on `miso`. The sweep covers every payload length under each of three modes: parity off, parity on, and parity on with byte mode. Both parity types and two payload patterns run in every mode. In one pass, a second `start` carrying a different word is injected part-way through the frame, and the bench checks that neither the data on the wire nor the slave select reacts to it.

// File: rtl/spi_par_pkg.sv
package spi_par_pkg;

    localparam int unsigned DEF_DATA_W   = 16;
    localparam int unsigned DEF_HALF_DIV = 2;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LEAD,
        ST_HIGH,
        ST_LOW
    } phase_e;

    typedef struct packed {
        logic par_active;
        logic odd;
    } frame_cfg_t;

    // parity bit that makes the total count of ones even (odd = 0) or odd (odd = 1)
    function automatic logic par_bit_of(input logic ones_xor, input logic odd);
        return ones_xor ^ odd;
    endfunction

endpackage

// File: rtl/spi_par_timer.sv
module spi_par_timer #(
    parameter int unsigned HALF_DIV = spi_par_pkg::DEF_HALF_DIV
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic tick
);
    localparam int unsigned CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

    logic [CW-1:0] cnt;

    assign tick = run && (cnt == CW'(HALF_DIV - 1));

    always_ff @(posedge clk) begin
        if (rst || !run || tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + CW'(1);
        end
    end
endmodule

// File: rtl/spi_par_txgen.sv
module spi_par_txgen
    import spi_par_pkg::*;
#(
    parameter int unsigned DATA_W = DEF_DATA_W,
    parameter int unsigned LEN_W  = $clog2(DATA_W),
    parameter int unsigned FW     = DATA_W + 1,
    parameter int unsigned NW     = $clog2(DATA_W + 2)
) (
    input  logic [DATA_W-1:0] data,
    input  logic [LEN_W-1:0]  len,
    input  logic              par_en,
    input  logic              odd,
    input  logic              byte_mode,
    output logic [FW-1:0]     frame,
    output logic [NW-1:0]     nbits,
    output logic              par_bit,
    output frame_cfg_t        cfg
);
    logic [DATA_W-1:0] masked;
    int unsigned       n_data;
    logic              active;

    always_comb begin
        n_data = (int'(len) >= int'(DATA_W)) ? DATA_W : int'(len) + 1;
        for (int i = 0; i < int'(DATA_W); i++) begin
            masked[i] = data[i] && (i < int'(n_data));
        end
        active         = par_en && !byte_mode;
        par_bit        = active ? par_bit_of(^masked, odd) : 1'b0;
        frame          = active ? {masked, par_bit} : {1'b0, masked};
        nbits          = NW'(n_data) + NW'(active);
        cfg.par_active = active;
        cfg.odd        = odd;
    end
endmodule

// File: rtl/spi_par_rxsplit.sv
module spi_par_rxsplit
    import spi_par_pkg::*;
#(
    parameter int unsigned DATA_W = DEF_DATA_W,
    parameter int unsigned FW     = DATA_W + 1
) (
    input  logic [FW-1:0]     sr,
    input  frame_cfg_t        cfg,
    output logic [DATA_W-1:0] data,
    output logic              par,
    output logic              err
);
    logic expect_par;

    always_comb begin
        data       = cfg.par_active ? sr[FW-1:1] : sr[DATA_W-1:0];
        expect_par = par_bit_of(^sr[FW-1:1], cfg.odd);
        par        = cfg.par_active && sr[0];
        err        = cfg.par_active && (sr[0] != expect_par);
    end
endmodule

// File: rtl/spi_par_master.sv
module spi_par_master
    import spi_par_pkg::*;
#(
    parameter int unsigned DATA_W   = DEF_DATA_W,
    parameter int unsigned HALF_DIV = DEF_HALF_DIV
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      start,
    input  logic [DATA_W-1:0]         tx_data,
    input  logic [$clog2(DATA_W)-1:0] data_len,
    input  logic                      par_en,
    input  logic                      par_odd,
    input  logic                      byte_mode,
    input  logic                      miso,
    output logic                      sclk,
    output logic                      mosi,
    output logic                      cs_n,
    output logic [DATA_W-1:0]         rx_data,
    output logic                      tx_par,
    output logic                      rx_par,
    output logic                      par_err,
    output logic                      done
);
    localparam int unsigned LEN_W = $clog2(DATA_W);
    localparam int unsigned FW    = DATA_W + 1;
    localparam int unsigned NW    = $clog2(DATA_W + 2);

    phase_e            phase;
    logic              tick;
    logic [FW-1:0]     frame_q;
    logic [NW-1:0]     left;
    frame_cfg_t        cfg_q;
    logic              txp_q;
    logic [FW-1:0]     rx_sr;

    logic [FW-1:0]     gen_frame;
    logic [NW-1:0]     gen_nbits;
    logic              gen_par;
    frame_cfg_t        gen_cfg;
    logic [DATA_W-1:0] rxs_data;
    logic              rxs_par;
    logic              rxs_err;

    spi_par_timer #(.HALF_DIV(HALF_DIV)) u_timer (
        .clk  (clk),
        .rst  (rst),
        .run  (phase != ST_IDLE),
        .tick (tick)
    );

    spi_par_txgen #(.DATA_W(DATA_W), .LEN_W(LEN_W), .FW(FW), .NW(NW)) u_txgen (
        .data      (tx_data),
        .len       (data_len),
        .par_en    (par_en),
        .odd       (par_odd),
        .byte_mode (byte_mode),
        .frame     (gen_frame),
        .nbits     (gen_nbits),
        .par_bit   (gen_par),
        .cfg       (gen_cfg)
    );

    spi_par_rxsplit #(.DATA_W(DATA_W), .FW(FW)) u_rxsplit (
        .sr   (rx_sr),
        .cfg  (cfg_q),
        .data (rxs_data),
        .par  (rxs_par),
        .err  (rxs_err)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            phase   <= ST_IDLE;
            sclk    <= 1'b0;
            mosi    <= 1'b0;
            cs_n    <= 1'b1;
            done    <= 1'b0;
            frame_q <= '0;
            left    <= '0;
            cfg_q   <= '0;
            txp_q   <= 1'b0;
            rx_sr   <= '0;
            rx_data <= '0;
            tx_par  <= 1'b0;
            rx_par  <= 1'b0;
            par_err <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (phase)
                ST_IDLE: begin
                    if (start) begin
                        frame_q <= gen_frame;
                        left    <= gen_nbits;
                        cfg_q   <= gen_cfg;
                        txp_q   <= gen_par;
                        rx_sr   <= '0;
                        mosi    <= gen_frame[gen_nbits - NW'(1)];
                        cs_n    <= 1'b0;
                        phase   <= ST_LEAD;
                    end
                end
                ST_LEAD: begin
                    if (tick) begin
                        sclk  <= 1'b1;
                        rx_sr <= {rx_sr[FW-2:0], miso};
                        left  <= left - NW'(1);
                        phase <= ST_HIGH;
                    end
                end
                ST_HIGH: begin
                    if (tick) begin
                        sclk  <= 1'b0;
                        phase <= ST_LOW;
                        if (left != '0) begin
                            mosi <= frame_q[left - NW'(1)];
                        end
                    end
                end
                ST_LOW: begin
                    if (tick) begin
                        if (left == '0) begin
                            cs_n    <= 1'b1;
                            done    <= 1'b1;
                            mosi    <= 1'b0;
                            rx_data <= rxs_data;
                            rx_par  <= rxs_par;
                            par_err <= rxs_err;
                            tx_par  <= txp_q;
                            phase   <= ST_IDLE;
                        end else begin
                            sclk  <= 1'b1;
                            rx_sr <= {rx_sr[FW-2:0], miso};
                            left  <= left - NW'(1);
                            phase <= ST_HIGH;
                        end
                    end
                end
                default: phase <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/spi_par_checker.sv
module spi_par_checker (
    input logic clk,
    input logic rst,
    input logic sclk,
    input logic mosi,
    input logic cs_n,
    input logic done,
    input logic tx_par,
    input logic rx_par,
    input logic par_err,
    input logic par_act
);
    // R8: clock idles low outside a frame
    p_sclk_idle_r8: assert property (@(posedge clk) disable iff (rst)
        cs_n |-> !sclk);

    // R8: mosi holds while sclk is high
    p_mosi_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (sclk && $past(sclk)) |-> $stable(mosi));

    // R8: no clock edge in the cycle the select falls
    p_lead_low_r8: assert property (@(posedge clk) disable iff (rst)
        $fell(cs_n) |-> !sclk);

    // R9: done coincides with the select returning high
    p_done_at_release_r9: assert property (@(posedge clk) disable iff (rst)
        done |-> $rose(cs_n));

    // R9: done lasts one clock
    p_done_single_r9: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R4: no parity status from a frame without parity
    p_nopar_status_r4: assert property (@(posedge clk) disable iff (rst)
        (done && !par_act) |-> (!tx_par && !rx_par && !par_err));
endmodule

bind spi_par_master spi_par_checker u_chk (
    .clk     (clk),
    .rst     (rst),
    .sclk    (sclk),
    .mosi    (mosi),
    .cs_n    (cs_n),
    .done    (done),
    .tx_par  (tx_par),
    .rx_par  (rx_par),
    .par_err (par_err),
    .par_act (cfg_q.par_active)
);

// File: tb/spi_par_master_bench.sv
module spi_par_master_bench;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 16;
    localparam int HD = 2;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic [DW-1:0] tx_data = '0;
    logic [3:0]    data_len = '0;
    logic          par_en = 1'b0;
    logic          par_odd = 1'b0;
    logic          byte_mode = 1'b0;
    logic          miso = 1'b0;
    logic          sclk, mosi, cs_n, tx_par, rx_par, par_err, done;
    logic [DW-1:0] rx_data;

    int total = 0;
    int bad = 0;

    // slave model state
    logic [DW:0] s_frame = '0;
    int          s_idx = 0;
    logic [DW:0] cap = '0;
    int          ncap = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_par_master #(.DATA_W(DW), .HALF_DIV(HD)) u_spi_par_master (
        .clk(clk), .rst(rst), .start(start), .tx_data(tx_data),
        .data_len(data_len), .par_en(par_en), .par_odd(par_odd),
        .byte_mode(byte_mode), .miso(miso), .sclk(sclk), .mosi(mosi),
        .cs_n(cs_n), .rx_data(rx_data), .tx_par(tx_par), .rx_par(rx_par),
        .par_err(par_err), .done(done)
    );

    always @(negedge cs_n) miso = s_frame[s_idx];
    always @(negedge sclk) begin
        if (!cs_n) begin
            if (s_idx > 0) s_idx = s_idx - 1;
            miso = s_frame[s_idx];
        end
    end
    always @(posedge sclk) begin
        cap  = {cap[DW-1:0], mosi};
        ncap = ncap + 1;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic run_frame(input logic [DW-1:0] d, input int len, input bit en,
                             input bit odd, input bit byt, input logic [DW-1:0] sd_raw,
                             input bit flip, input bit poke);
        logic [DW:0]   mask;
        logic [DW-1:0] dm, sd;
        logic [DW:0]   exp_f;
        bit            act, tp, sp;
        int            nb, low_cnt, lead_cnt, done_cnt, smp;
        bit            seen_clk, seen_done, first_high_done;
        mask  = (17'h1 << (len + 1)) - 17'h1;
        dm    = d & mask[DW-1:0];
        sd    = sd_raw & mask[DW-1:0];
        act   = en && !byt;
        tp    = act ? ((^dm) ^ odd) : 1'b0;
        sp    = ((^sd) ^ odd) ^ flip;
        nb    = len + 1 + (act ? 1 : 0);
        exp_f = act ? {dm, tp} : {1'b0, dm};
        s_frame = act ? {sd, sp} : {1'b0, sd};
        s_idx = nb - 1;
        cap   = '0;
        ncap  = 0;
        @(negedge clk);
        tx_data = d; data_len = 4'(len); par_en = en; par_odd = odd; byte_mode = byt;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        low_cnt = 0; lead_cnt = 0; done_cnt = 0; smp = 0;
        seen_clk = 0; seen_done = 0; first_high_done = 0;
        while (!seen_done && smp < 200) begin
            if (!cs_n) begin
                low_cnt++;
                if (sclk) seen_clk = 1;
                if (!seen_clk) lead_cnt++;
            end else begin
                if (done) begin
                    seen_done = 1;
                    first_high_done = 1;
                    done_cnt++;
                end
            end
            smp++;
            if (poke && smp == 7) begin
                tx_data = ~d; data_len = 4'd15; start = 1'b1;
            end else begin
                start = 1'b0;
            end
            if (!seen_done) @(negedge clk);
        end
        start = 1'b0;
        chk(first_high_done, "R9", "done at first idle cycle", 32'(first_high_done), 1);
        chk(low_cnt == (2*nb + 1)*HD, "R9", "cs_n low cycles", low_cnt, (2*nb + 1)*HD);
        chk(lead_cnt == HD, "R8", "lead cycles", lead_cnt, HD);
        chk(ncap == nb, act ? "R2" : "R4", "frame bits", ncap, nb);
        chk(cap == exp_f, act ? "R3" : "R1", "mosi frame", 32'(cap), 32'(exp_f));
        chk(tx_par == tp, act ? "R5" : "R4", "tx_par", 32'(tx_par), 32'(tp));
        chk(rx_data == sd, "R6", "rx_data", 32'(rx_data), 32'(sd));
        chk(rx_par == (act ? sp : 1'b0), act ? "R6" : "R4", "rx_par", 32'(rx_par), 32'(act ? sp : 1'b0));
        chk(par_err == (act && flip), act ? "R7" : "R4", "par_err", 32'(par_err), 32'(act && flip));
        @(negedge clk);
        chk(!done, "R9", "done width", 32'(done), 0);
        if (poke) begin
            for (int k = 0; k < 4*HD + 4; k++) begin
                chk(cs_n && !sclk, "R10", "no second frame", {30'd0, cs_n, sclk}, 32'h2);
                @(negedge clk);
            end
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11 reset state
        chk(cs_n == 1'b1, "R11", "cs_n", 32'(cs_n), 1);
        chk(sclk == 1'b0 && mosi == 1'b0 && done == 1'b0, "R11", "sclk/mosi/done",
            {29'd0, sclk, mosi, done}, 0);
        chk(rx_data == '0 && !tx_par && !rx_par && !par_err, "R11", "status",
            {12'd0, rx_data, tx_par, rx_par, par_err, 1'b0}, 0);

        for (int len = 0; len < 16; len++) begin
            for (int mode = 0; mode < 3; mode++) begin
                for (int odd = 0; odd < 2; odd++) begin
                    for (int pat = 0; pat < 2; pat++) begin
                        logic [DW-1:0] d;
                        logic [DW-1:0] s;
                        bit flip;
                        d = (pat == 0) ? (16'hA5C3 ^ 16'(len * 16'h1111)) : (16'h7E01 + 16'(len * 37));
                        s = (pat == 0) ? (16'h3C96 + 16'(len * 101)) : ~(16'h0F0F ^ 16'(len));
                        flip = ((len + odd + pat) % 3) == 0;
                        run_frame(d, len, mode != 0, odd[0], mode == 2, s, flip, 1'b0);
                    end
                end
            end
        end
        // R10: start pulse during a frame
        run_frame(16'h1234, 15, 1'b1, 1'b0, 1'b0, 16'hBEEF, 1'b0, 1'b1);
        run_frame(16'hFFFF, 7, 1'b1, 1'b1, 1'b0, 16'h00FF, 1'b1, 1'b1);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule